// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Stage

This block is one presettable counter stage, four bits wide by default, that moves up or down by one on each rising clock edge when it is allowed to. A parameter chooses between a binary stage that wraps modulo 16 and a decade stage that steps through 0 to 9. A synchronous active-low load copies a parallel data word into the count. Two active-low count enables, `en_p_n` and `en_t_n`, must both be low for the stage to advance. A direction input picks increment or decrement.

The stage drives an active-low ripple-carry output, `rco_n`. It goes low when `en_t_n` is low and the count sits at the terminal value for the current direction: the top value when counting up, zero when counting down. To build a wider counter, connect each stage's `rco_n` to the `en_t_n` of the next stage, and share the clock, load, direction and `en_p_n` across all stages. The chain then behaves as one wide synchronous counter and needs no extra gates.

Top module: `casc_updown_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 at that edge.
- R2: When `load_n` is low at a rising edge, the count takes `data_in` at that edge, whatever the levels of `en_p_n`, `en_t_n` and `up`.
- R3: When `load_n` is high and either `en_p_n` or `en_t_n` is high at a rising edge, the count keeps its value.
- R4: When `load_n`, `en_p_n` and `en_t_n` enable counting and `up` is 1, the count rises by one per edge. In binary mode 15 is followed by 0.
- R5: When counting is enabled and `up` is 0, the count falls by one per edge. In binary mode 0 is followed by 15.
- R6: In decade mode an up count goes from 9 to 0, a down count goes from 0 to 9, and counting from any value in 0..9 never leaves that range.
- R7: In decade mode with a loaded value in 10..15, the next up count gives 0. A down count decrements normally until the value is back in range. `rco_n` stays high for every such value.
- R8: `rco_n` is 0 exactly when `en_t_n` is 0 and the count equals the terminal value: 15 (binary) or 9 (decade) with `up`=1, and 0 with `up`=0. `en_p_n` has no effect on `rco_n`.
- R9: `rco_n` follows changes on `en_t_n` and `up` between clock edges, with no clock edge needed. Such changes leave the count unchanged until the next edge.
- R10: Two stages chained through `rco_n` into `en_t_n` count as one 8-bit binary counter (modulo 256) or as a two-digit decade counter (modulo 100), in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| data_in | input | WIDTH | Value copied in on a load |
| en_p_n | input | 1 | Active-low count enable, shared along a chain |
| en_t_n | input | 1 | Active-low count enable that also gates the carry |
| up | input | 1 | 1 counts up, 0 counts down |
| count | output | WIDTH | Current count |
| rco_n | output | 1 | Active-low terminal-count carry for the next stage |

## Verification
The bound checker looks at every edge of every instance. It checks the load, the hold, the single step up or down, the wrap at both ends of the range, and that a low carry only ever appears with `en_t_n` low and the count at the terminal value for the current direction. Some behaviours only show up under the bench's directed scenarios: cascading into an 8-bit or two-digit value, recovery from out-of-range decade loads, and `rco_n` reacting to `en_t_n` and `up` in the middle of a cycle. The bench compares these against a behavioural model of two chained stages of each kind.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // What the stage does at the coming rising edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } ctr_op_e;

    // Control inputs as sampled by the stage
    typedef struct packed {
        logic load_n;
        logic en_p_n;
        logic en_t_n;
        logic up;
    } ctr_ctl_t;

    // Largest legal count: 9 for a decade stage, all ones otherwise
    function automatic int unsigned term_max(int unsigned width, bit decade);
        return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
    endfunction

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import ctr_pkg::*;
(
    input  ctr_ctl_t ctl,
    output ctr_op_e  op
);

    always_comb begin
        if (!ctl.load_n) begin
            op = OP_LOAD;
        end else if (!ctl.en_p_n && !ctl.en_t_n) begin
            op = ctl.up ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/ctr_next_val.sv
module ctr_next_val
    import ctr_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          IS_DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] data,
    input  ctr_op_e          op,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH-1:0] inc_v;
    logic [WIDTH-1:0] dec_v;

    generate
        if (IS_DECADE) begin : g_dec
            localparam logic [WIDTH-1:0] TOP_V = WIDTH'(term_max(WIDTH, IS_DECADE));
            // Out-of-range values (above TOP_V) fold to zero on an up step
            always_comb begin
                inc_v = (cur >= TOP_V) ? '0 : cur + 1'b1;
                dec_v = (cur == '0) ? TOP_V : cur - 1'b1;
            end
        end else begin : g_bin
            // Natural modulo-2^WIDTH wrap
            always_comb begin
                inc_v = cur + 1'b1;
                dec_v = cur - 1'b1;
            end
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = data;
            OP_INC:  nxt = inc_v;
            OP_DEC:  nxt = dec_v;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_term_detect.sv
module ctr_term_detect
    import ctr_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          IS_DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             en_t_n,
    output logic             rco_n
);

    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(term_max(WIDTH, IS_DECADE));

    logic at_top;
    logic at_zero;
    logic at_term;

    assign at_top  = (cur == TOP_V);
    assign at_zero = (cur == '0);
    assign at_term = up ? at_top : at_zero;
    assign rco_n   = ~(~en_t_n & at_term);

endmodule

// File: rtl/casc_updown_ctr.sv
module casc_updown_ctr
    import ctr_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          IS_DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             en_p_n,
    input  logic             en_t_n,
    input  logic             up,
    output logic [WIDTH-1:0] count,
    output logic             rco_n
);

    ctr_ctl_t         ctl;
    ctr_op_e          op;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    always_comb begin
        ctl.load_n = load_n;
        ctl.en_p_n = en_p_n;
        ctl.en_t_n = en_t_n;
        ctl.up     = up;
    end

    ctr_op_decode u_dec (
        .ctl (ctl),
        .op  (op)
    );

    ctr_next_val #(
        .WIDTH     (WIDTH),
        .IS_DECADE (IS_DECADE)
    ) u_next (
        .cur  (cnt_q),
        .data (data_in),
        .op   (op),
        .nxt  (cnt_d)
    );

    // All state bits change together on the rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    ctr_term_detect #(
        .WIDTH     (WIDTH),
        .IS_DECADE (IS_DECADE)
    ) u_term (
        .cur    (cnt_q),
        .up     (up),
        .en_t_n (en_t_n),
        .rco_n  (rco_n)
    );

    assign count = cnt_q;

endmodule

// File: rtl/casc_updown_ctr_chk.sv
module casc_updown_ctr_chk
    import ctr_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          IS_DECADE = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             load_n,
    input logic [WIDTH-1:0] data_in,
    input logic             en_p_n,
    input logic             en_t_n,
    input logic             up,
    input logic [WIDTH-1:0] count,
    input logic             rco_n
);

    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(term_max(WIDTH, IS_DECADE));

    logic stepping;
    assign stepping = load_n && !en_p_n && !en_t_n;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> count == $past(data_in));

    // R3
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && (en_p_n || en_t_n)) |=> $stable(count));

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (stepping && up && count < TOP_V) |=> count == WIDTH'($past(count) + 1'b1));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (stepping && !up && count != '0) |=> count == WIDTH'($past(count) - 1'b1));

    // R6
    wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (stepping && up && count >= TOP_V) |=> count == '0);

    // R6
    wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
        (stepping && !up && count == '0) |=> count == TOP_V);

    // R8
    carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rco_n |-> (!en_t_n && (up ? (count == TOP_V) : (count == '0))));

    // R7
    carry_range_chk: assert property (@(posedge clk) disable iff (rst)
        !rco_n |-> count <= TOP_V);

endmodule

bind casc_updown_ctr casc_updown_ctr_chk #(
    .WIDTH     (WIDTH),
    .IS_DECADE (IS_DECADE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_n  (load_n),
    .data_in (data_in),
    .en_p_n  (en_p_n),
    .en_t_n  (en_t_n),
    .up      (up),
    .count   (count),
    .rco_n   (rco_n)
);

// File: tb/tb_casc_updown_ctr.sv
`timescale 1ns/1ps
module tb_casc_updown_ctr;

    logic       clk  = 1'b0;
    logic       rst  = 1'b1;
    logic       ld_n = 1'b1;
    logic       p_n  = 1'b1;
    logic       t_n  = 1'b1;
    logic       up   = 1'b1;
    logic [7:0] bdat = 8'h00;
    logic [7:0] ddat = 8'h00;

    logic [3:0] bq0, bq1, dq0, dq1;
    logic       brc0, brc1, drc0, drc1;

    int  checks = 0;
    int  fails  = 0;
    int  mb0 = 0, mb1 = 0, md0 = 0, md1 = 0;
    int  wide_b = 0, wide_d = 0;
    bit  wide_d_ok = 1'b1;

    always #2.5 clk = ~clk;   // 200 MHz

    casc_updown_ctr #(.WIDTH(4), .IS_DECADE(1'b0)) dut (
        .clk(clk), .rst(rst), .load_n(ld_n), .data_in(bdat[3:0]),
        .en_p_n(p_n), .en_t_n(t_n), .up(up), .count(bq0), .rco_n(brc0));
    casc_updown_ctr #(.WIDTH(4), .IS_DECADE(1'b0)) dut_hi (
        .clk(clk), .rst(rst), .load_n(ld_n), .data_in(bdat[7:4]),
        .en_p_n(p_n), .en_t_n(brc0), .up(up), .count(bq1), .rco_n(brc1));
    casc_updown_ctr #(.WIDTH(4), .IS_DECADE(1'b1)) dec_lo (
        .clk(clk), .rst(rst), .load_n(ld_n), .data_in(ddat[3:0]),
        .en_p_n(p_n), .en_t_n(t_n), .up(up), .count(dq0), .rco_n(drc0));
    casc_updown_ctr #(.WIDTH(4), .IS_DECADE(1'b1)) dec_hi (
        .clk(clk), .rst(rst), .load_n(ld_n), .data_in(ddat[7:4]),
        .en_p_n(p_n), .en_t_n(drc0), .up(up), .count(dq1), .rco_n(drc1));

    function automatic int lim(bit dec);
        return dec ? 9 : 15;
    endfunction

    function automatic bit term(int v, bit dec, bit tn, bit u);
        return !tn && (u ? (v == lim(dec)) : (v == 0));
    endfunction

    function automatic int adv(int v, bit dec, bit u);
        if (u) return (v >= lim(dec)) ? 0 : v + 1;
        return (v == 0) ? lim(dec) : v - 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        bit lo_b, lo_d;
        lo_b = term(mb0, 1'b0, t_n, up);
        lo_d = term(md0, 1'b1, t_n, up);
        check(int'(bq0) == mb0, {req, " bin lo count"}, int'(bq0), mb0);
        check(int'(bq1) == mb1, {req, " bin hi count"}, int'(bq1), mb1);
        check(int'(dq0) == md0, {req, " dec lo count"}, int'(dq0), md0);
        check(int'(dq1) == md1, {req, " dec hi count"}, int'(dq1), md1);
        // R8 carry of every stage
        check(brc0 == !lo_b, {req, " R8 bin lo rco_n"}, int'(brc0), int'(!lo_b));
        check(brc1 == !term(mb1, 1'b0, !lo_b, up), {req, " R8 bin hi rco_n"},
              int'(brc1), int'(!term(mb1, 1'b0, !lo_b, up)));
        check(drc0 == !lo_d, {req, " R8 dec lo rco_n"}, int'(drc0), int'(!lo_d));
        check(drc1 == !term(md1, 1'b1, !lo_d, up), {req, " R8 dec hi rco_n"},
              int'(drc1), int'(!term(md1, 1'b1, !lo_d, up)));
    endtask

    // One rising edge: update the model with the inputs seen there, then compare
    task automatic tick(string req);
        bit cb, cd;
        @(posedge clk);
        cb = term(mb0, 1'b0, t_n, up);
        cd = term(md0, 1'b1, t_n, up);
        if (rst) begin
            mb0 = 0; mb1 = 0; md0 = 0; md1 = 0; wide_b = 0; wide_d = 0;
        end else if (!ld_n) begin
            mb0 = int'(bdat[3:0]); mb1 = int'(bdat[7:4]);
            md0 = int'(ddat[3:0]); md1 = int'(ddat[7:4]);
            wide_b = int'(bdat);
            wide_d = int'(ddat[7:4]) * 10 + int'(ddat[3:0]);
        end else if (!p_n) begin
            if (!t_n) begin
                mb0 = adv(mb0, 1'b0, up);
                md0 = adv(md0, 1'b1, up);
                wide_b = up ? (wide_b + 1) % 256 : (wide_b + 255) % 256;
                wide_d = up ? (wide_d + 1) % 100 : (wide_d + 99) % 100;
            end
            if (cb) mb1 = adv(mb1, 1'b0, up);
            if (cd) md1 = adv(md1, 1'b1, up);
        end
        @(negedge clk);
        compare(req);
        // R10 cascade seen as one wide counter
        check(int'(bq1) * 16 + int'(bq0) == wide_b, "R10 8-bit binary value",
              int'(bq1) * 16 + int'(bq0), wide_b);
        if (wide_d_ok)
            check(int'(dq1) * 10 + int'(dq0) == wide_d, "R10 two-digit decade value",
                  int'(dq1) * 10 + int'(dq0), wide_d);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        rst = 1'b1;
        tick("R1");
        tick("R1");
        rst = 1'b0;

        // R2 load with enables inactive, then with enables active
        ld_n = 1'b0; bdat = 8'hF0; ddat = 8'h95; p_n = 1'b1; t_n = 1'b1;
        tick("R2");
        bdat = 8'h3C; ddat = 8'h47; p_n = 1'b0; t_n = 1'b0; up = 1'b0;
        tick("R2");

        // R4 R6 R10 long up run crossing both wide wraps
        ld_n = 1'b1; up = 1'b1;
        for (int i = 0; i < 300; i++) tick("R4 R6");

        // R3 hold through either enable
        p_n = 1'b1;
        for (int i = 0; i < 5; i++) tick("R3 p high");
        p_n = 1'b0; t_n = 1'b1;
        for (int i = 0; i < 5; i++) tick("R3 t high");

        // R5 R6 R10 long down run
        t_n = 1'b0; up = 1'b0;
        for (int i = 0; i < 300; i++) tick("R5 R6");

        // R9 carry reacts between edges; count does not
        ld_n = 1'b0; bdat = 8'h0F; ddat = 8'h09; up = 1'b1;
        tick("R2");
        ld_n = 1'b1; p_n = 1'b1; t_n = 1'b1;
        #1 compare("R9 t high");
        t_n = 1'b0;
        #1 compare("R9 t low");
        up = 1'b0;
        #1 compare("R9 up low");
        up = 1'b1;
        #1 compare("R9 up high");
        p_n = 1'b0;
        #1 compare("R8 p low");
        p_n = 1'b1;
        #1 compare("R8 p high");
        tick("R9 hold");

        // R7 out-of-range decade values
        wide_d_ok = 1'b0;
        ld_n = 1'b0; ddat = 8'h0C; up = 1'b1;
        tick("R7 load");
        ld_n = 1'b1; p_n = 1'b0; t_n = 1'b0;
        for (int i = 0; i < 6; i++) tick("R7 up");
        ld_n = 1'b0; ddat = 8'h0F; up = 1'b0;
        tick("R7 load");
        ld_n = 1'b1;
        for (int i = 0; i < 10; i++) tick("R7 down");
        ld_n = 1'b0; ddat = 8'hAB; up = 1'b1;
        tick("R7 load");
        ld_n = 1'b1;
        for (int i = 0; i < 4; i++) tick("R7 up");

        // R1 reset in the middle of a run
        rst = 1'b1;
        tick("R1");
        rst = 1'b0; wide_d_ok = 1'b1;
        for (int i = 0; i < 12; i++) tick("R4 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule